// File: doc/BRIEF.md
# Six-Channel Phase-Staggered LED Dimmer

This block drives six LED string gates from one shared brightness level. A free-running period counter of 255 clock cycles is shared by all channels. Each enabled channel holds its gate high for as many counts as the brightness code, starting at its own offset into the period. The offsets are spread so that the LED strings do not all switch at the same instant, which lowers the peak current drawn from the supply.

Software-style writes set four things: the brightness level, a channel-enable mask, a phase mode and a 7-bit phase step. The offsets follow one of two rules. Under the fixed rule, each enabled channel starts a fixed step after the enabled channel below it. Under the even rule, the enabled channels share the period equally. A mode pin selects direct operation instead. In that mode an external PWM waveform passes to the gates, and each channel sees it delayed by a multiple of the step, counted in clock cycles; one clock is one tick of the delay timebase.

Configuration changes are held back until the period wraps, so no gate sees a mid-period change. Fault inputs from the analog side force their channel low at once. The mask readback reports which channels are both enabled and fault-free.

Top module: `pwm_phase_dimmer`

## Requirements
- R1: After reset the level register reads 0xFF, the mask register reads 0x3F and the phase register reads 0x00. The gates are low while reset is asserted.
- R2: Register selection by `addr_i`: 0 is the level (8 bits); 1 is the channel mask (bit k enables channel k); 2 is the phase register (bit 7 selects the even rule, bits 6:0 hold the step); 3 ignores writes and reads 0.
- R3: The counter period is 255 clocks. An enabled, fault-free channel in counter mode is high for exactly `level` clocks in every 255-clock window. Level 0 keeps it low and level 255 keeps it high.
- R4: Under the fixed rule, the enabled channel of rank r starts its high window (r × step) mod 255 counts after counter zero. Rank r is the number of enabled channels with a lower index. The gate is registered, so it appears one clock after the counter value.
- R5: Under the even rule with N enabled channels, the offset is r × floor(255 / N).
- R6: A channel whose active mask bit is 0 is low. With the mask all zero, every gate is low.
- R7: A written level, mask, phase setting or mode-pin value applies only from the next counter wrap, that is, from the cycle after the counter reads 254.
- R8: A channel whose fault input is high is low from the next clock. It follows the normal rules again once the fault input clears.
- R9: With the mode pin latched high, the gate of the enabled channel of rank r equals `ext_pwm_i` delayed by r × step clocks, plus the one output register stage.
- R10: Reading address 1 returns the written mask ANDed with the inverse of `fault_i`. Bits above 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the direct-mode delay tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the selected register |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| dir_sel_i | input | 1 | Direct mode select, latched at the period wrap |
| ext_pwm_i | input | 1 | External PWM waveform for direct mode |
| fault_i | input | 6 | Per-channel fault flags |
| gate_o | output | 6 | Channel gate outputs |

## Verification
Directed runs cover the extreme levels 0 and 255 and a mid level, which separate an off-by-one in the duty compare from a correct one. Sparse masks under both phase rules check that ranks count only enabled channels and that offsets past 255 wrap. Direct mode runs with steps of 0, 3 and 127 against a randomly toggling external waveform, which exposes a wrong tap or a missing rank factor. Seeded random rounds then write registers at random moments, so updates land both mid-period and at the wrap, and fault flags are toggled; a cycle-accurate model in the bench compares every gate on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   // Register select codes
   typedef enum logic [1:0] {
      SEL_LEVEL = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_PHASE = 2'd2,
      SEL_SPARE = 2'd3
   } reg_sel_e;

   // Period of a counter of the given width: all codes but the top one
   function automatic int period_of(input int bw);
      return (1 << bw) - 1;
   endfunction

   // Longest direct-mode delay: highest rank times the largest step
   function automatic int max_delay(input int nch, input int psw);
      return (nch - 1) * ((1 << psw) - 1);
   endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_pkg::*;
#(
   parameter int NCH = 6,
   parameter int BW  = 8,
   parameter int PSW = 7
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           wr_en_i,
   input  logic [1:0]     addr_i,
   input  logic [BW-1:0]  wdata_i,
   input  logic [NCH-1:0] fault_i,
   input  logic           dir_sel_i,
   input  logic           bound_i,
   output logic [BW-1:0]  act_level_o,
   output logic [NCH-1:0] act_mask_o,
   output logic           act_even_o,
   output logic [PSW-1:0] act_step_o,
   output logic           act_dir_o,
   output logic [BW-1:0]  rdata_o
);

   reg_sel_e       sel;
   logic [BW-1:0]  sh_level;
   logic [NCH-1:0] sh_mask;
   logic           sh_even;
   logic [PSW-1:0] sh_step;

   assign sel = reg_sel_e'(addr_i);

   // Written (shadow) copies
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_level <= '1;
         sh_mask  <= '1;
         sh_even  <= 1'b0;
         sh_step  <= '0;
      end else if (wr_en_i) begin
         case (sel)
            SEL_LEVEL: sh_level <= wdata_i;
            SEL_MASK:  sh_mask  <= wdata_i[NCH-1:0];
            SEL_PHASE: begin
               sh_even <= wdata_i[PSW];
               sh_step <= wdata_i[PSW-1:0];
            end
            default: ;
         endcase
      end
   end

   // Active copies, refreshed only when the period wraps
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_level_o <= '1;
         act_mask_o  <= '1;
         act_even_o  <= 1'b0;
         act_step_o  <= '0;
         act_dir_o   <= 1'b0;
      end else if (bound_i) begin
         act_level_o <= sh_level;
         act_mask_o  <= sh_mask;
         act_even_o  <= sh_even;
         act_step_o  <= sh_step;
         act_dir_o   <= dir_sel_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_LEVEL: rdata_o = sh_level;
         SEL_MASK:  rdata_o = BW'(sh_mask & ~fault_i);
         SEL_PHASE: rdata_o = BW'({sh_even, sh_step});
         default:   rdata_o = '0;
      endcase
   end

   // R7: active settings move only at the wrap
   p_hold_midperiod_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bound_i |=> ($stable(act_level_o) && $stable(act_mask_o) && $stable(act_even_o)
                    && $stable(act_step_o) && $stable(act_dir_o)));

endmodule

// File: rtl/pwm_phase_calc.sv
module pwm_phase_calc
   import pwm_pkg::*;
#(
   parameter int NCH = 6,
   parameter int BW  = 8,
   parameter int PSW = 7,
   parameter int DW  = 10
) (
   input  logic [NCH-1:0]         mask_i,
   input  logic                   even_i,
   input  logic [PSW-1:0]         step_i,
   output logic [NCH-1:0][BW-1:0] off_o,
   output logic [NCH-1:0][DW-1:0] dly_o
);

   localparam int PERIOD = period_of(BW);
   localparam int RW     = $clog2(NCH + 1);
   localparam int MW     = BW + RW;

   logic [RW-1:0] n_en;
   logic [BW-1:0] even_step;
   logic [BW-1:0] unit;

   always_comb begin
      n_en = '0;
      for (int j = 0; j < NCH; j++) n_en = n_en + RW'(mask_i[j]);
   end

   // Equal share of the period for each possible number of enabled channels
   always_comb begin
      even_step = '0;
      for (int i = 1; i <= NCH; i++) begin
         if (n_en == RW'(i)) even_step = BW'(PERIOD / i);
      end
   end

   assign unit = even_i ? even_step : BW'(step_i);

   for (genvar k = 0; k < NCH; k++) begin : g_rank
      logic [RW-1:0] rank;
      logic [MW-1:0] prod;

      always_comb begin
         rank = '0;
         for (int j = 0; j < k; j++) rank = rank + RW'(mask_i[j]);
      end

      assign prod     = MW'(rank) * MW'(unit);
      assign off_o[k] = BW'(prod % MW'(PERIOD));
      assign dly_o[k] = DW'(rank) * DW'(step_i);
   end

endmodule

// File: rtl/pwm_delay_line.sv
module pwm_delay_line #(
   parameter int DEPTH = 635
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             d_i,
   output logic [DEPTH-1:0] hist_o
);

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hist_o <= '0;
         else         hist_o <= d_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hist_o <= '0;
         else         hist_o <= {hist_o[DEPTH-2:0], d_i};
      end
   end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
   import pwm_pkg::*;
#(
   parameter int BW    = 8,
   parameter int DW    = 10,
   parameter int DEPTH = 635
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [BW-1:0]    cnt_i,
   input  logic [BW-1:0]    level_i,
   input  logic [BW-1:0]    off_i,
   input  logic [DW-1:0]    dly_i,
   input  logic [DEPTH-1:0] hist_i,
   input  logic             ext_i,
   input  logic             en_i,
   input  logic             fault_i,
   input  logic             dir_i,
   output logic             gate_o
);

   localparam int PERIOD = period_of(BW);

   logic [BW:0] pos;
   logic        win;
   logic        tap;

   // Position within this lane's shifted period
   always_comb begin
      if (cnt_i >= off_i) pos = {1'b0, cnt_i} - {1'b0, off_i};
      else                pos = {1'b0, cnt_i} + (BW+1)'(PERIOD) - {1'b0, off_i};
   end

   assign win = (pos < {1'b0, level_i});
   assign tap = (dly_i == '0) ? ext_i : hist_i[dly_i - DW'(1)];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_o <= 1'b0;
      else         gate_o <= en_i & ~fault_i & (dir_i ? tap : win);
   end

   // R8: a faulted lane is low on the next clock
   p_fault_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> !gate_o);

   // R6: a disabled lane is low
   p_disabled_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !gate_o);

   // R9: with zero delay the lane copies the external input
   p_direct_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_i && en_i && !fault_i && dly_i == '0) |=> (gate_o == $past(ext_i)));

endmodule

// File: rtl/pwm_phase_dimmer.sv
module pwm_phase_dimmer
   import pwm_pkg::*;
#(
   parameter int NCH = 6,
   parameter int BW  = 8,
   parameter int PSW = 7
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           wr_en_i,
   input  logic [1:0]     addr_i,
   input  logic [BW-1:0]  wdata_i,
   output logic [BW-1:0]  rdata_o,
   input  logic           dir_sel_i,
   input  logic           ext_pwm_i,
   input  logic [NCH-1:0] fault_i,
   output logic [NCH-1:0] gate_o
);

   localparam int PERIOD = period_of(BW);
   localparam int DEPTH  = max_delay(NCH, PSW);
   localparam int DW     = $clog2(DEPTH + 1);

   if (NCH < 2)       begin : g_bad_nch  $error("NCH must be at least 2");          end
   if (NCH > BW)      begin : g_bad_mask $error("mask must fit the data width");     end
   if (PSW < 1)       begin : g_bad_psw  $error("PSW must be at least 1");          end
   if (PSW + 1 > BW)  begin : g_bad_phs  $error("phase field must fit data width"); end

   logic [BW-1:0]          cnt_q;
   logic                   bound;
   logic [BW-1:0]          act_level;
   logic [NCH-1:0]         act_mask;
   logic                   act_even;
   logic [PSW-1:0]         act_step;
   logic                   act_dir;
   logic [NCH-1:0][BW-1:0] off;
   logic [NCH-1:0][DW-1:0] dly;
   logic [DEPTH-1:0]       hist;

   assign bound = (cnt_q == BW'(PERIOD - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (bound) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   pwm_cfg_regs #(.NCH(NCH), .BW(BW), .PSW(PSW)) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .fault_i     (fault_i),
      .dir_sel_i   (dir_sel_i),
      .bound_i     (bound),
      .act_level_o (act_level),
      .act_mask_o  (act_mask),
      .act_even_o  (act_even),
      .act_step_o  (act_step),
      .act_dir_o   (act_dir),
      .rdata_o     (rdata_o)
   );

   pwm_phase_calc #(.NCH(NCH), .BW(BW), .PSW(PSW), .DW(DW)) i_phase (
      .mask_i (act_mask),
      .even_i (act_even),
      .step_i (act_step),
      .off_o  (off),
      .dly_o  (dly)
   );

   pwm_delay_line #(.DEPTH(DEPTH)) i_dline (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ext_pwm_i),
      .hist_o (hist)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_lane
      pwm_lane #(.BW(BW), .DW(DW), .DEPTH(DEPTH)) i_lane (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .cnt_i   (cnt_q),
         .level_i (act_level),
         .off_i   (off[k]),
         .dly_i   (dly[k]),
         .hist_i  (hist),
         .ext_i   (ext_pwm_i),
         .en_i    (act_mask[k]),
         .fault_i (fault_i[k]),
         .dir_i   (act_dir),
         .gate_o  (gate_o[k])
      );
   end

   // R3: counter stays inside the 255-count period
   p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < BW'(PERIOD));

   // R3: level 0 in counter mode keeps every gate low
   p_zero_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_dir && act_level == '0) |=> (gate_o == '0));

   // R3: full level on an enabled, healthy channel 0 keeps it high
   p_full_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_dir && act_level == BW'(PERIOD) && act_mask[0] && !fault_i[0]) |=> gate_o[0]);

endmodule

// File: tb/test_pwm_phase_dimmer.sv
`timescale 1ns/1ps
module test_pwm_phase_dimmer;

   localparam int NCH = 6;
   localparam int BW  = 8;
   localparam int PER = 255;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr = 1'b0;
   logic [1:0]     addr = '0;
   logic [BW-1:0]  wdata = '0;
   logic [BW-1:0]  rdata;
   logic           dsel = 1'b0;
   logic           ext = 1'b0;
   logic [NCH-1:0] fault = '0;
   logic [NCH-1:0] gate;

   always #2.5 clk = ~clk;

   pwm_phase_dimmer i_pwm_phase_dimmer (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .dir_sel_i (dsel),
      .ext_pwm_i (ext),
      .fault_i   (fault),
      .gate_o    (gate)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   string cur_req = "R1";
   bit    live = 1'b0;
   bit    ext_rand = 1'b0;
   bit    done = 1'b0;

   // Reference model state
   int             m_cnt;
   logic [7:0]     s_level, a_level;
   logic [5:0]     s_mask, a_mask;
   logic           s_even, a_even, a_dir;
   logic [6:0]     s_step, a_step;
   logic [1023:0]  hist;
   logic [5:0]     exp_gate;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         if (n_fail < 40)
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [5:0] f_gate(input int cnt, input logic [7:0] lvl,
      input logic [5:0] msk, input logic ev, input logic [6:0] st, input logic dir,
      input logic x, input logic [1023:0] h, input logic [5:0] flt);
      int n = 0;
      int r = 0;
      int unit, off, pos, d;
      logic [5:0] g = '0;
      logic v;
      for (int k = 0; k < NCH; k++) n += int'(msk[k]);
      unit = ev ? ((n > 0) ? PER / n : 0) : int'(st);
      for (int k = 0; k < NCH; k++) begin
         if (msk[k]) begin
            off = (r * unit) % PER;
            pos = (cnt - off + PER) % PER;
            if (dir) begin
               d = r * int'(st);
               v = (d == 0) ? x : h[d-1];
            end else begin
               v = (pos < int'(lvl));
            end
            g[k] = v & ~flt[k];
            r++;
         end
      end
      return g;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; s_level = 8'hFF; a_level = 8'hFF; s_mask = 6'h3F; a_mask = 6'h3F;
         s_even = 0; a_even = 0; s_step = 0; a_step = 0; a_dir = 0;
         hist = '0; exp_gate = '0;
      end else begin
         exp_gate = f_gate(m_cnt, a_level, a_mask, a_even, a_step, a_dir, ext, hist, fault);
         if (m_cnt == PER - 1) begin
            a_level = s_level; a_mask = s_mask; a_even = s_even;
            a_step = s_step; a_dir = dsel;
         end
         if (wr) begin
            case (addr)
               2'd0: s_level = wdata;
               2'd1: s_mask = wdata[5:0];
               2'd2: begin s_even = wdata[7]; s_step = wdata[6:0]; end
               default: ;
            endcase
         end
         m_cnt = (m_cnt + 1) % PER;
         hist = {hist[1022:0], ext};
      end
   end

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (live && rst_n) check(gate == exp_gate, cur_req, "gate", 32'(gate), 32'(exp_gate));
   end

   always @(negedge clk) begin
      if (ext_rand && $urandom_range(0, 3) == 0) ext <= ~ext;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_check(input logic [1:0] a, input logic [7:0] expv, input string req);
      @(negedge clk); addr = a; #1;
      check(rdata == expv, req, "rdata", 32'(rdata), 32'(expv));
   endtask

   task automatic wait_periods(input int n);
      repeat (n * PER) @(negedge clk);
   endtask

   task automatic window(input int ch, input int expv, input string req);
      int c = 0;
      repeat (PER) begin @(negedge clk); c += int'(gate[ch]); end
      check(c == expv, req, "high count", 32'(c), 32'(expv));
   endtask

   initial begin
      int s;
      s = $urandom(32'h5EED_0042);
      // R1: gates low in reset, defaults after
      repeat (4) @(negedge clk);
      check(gate == '0, "R1", "gate in reset", 32'(gate), 32'h0);
      rst_n = 1'b1;
      rd_check(2'd0, 8'hFF, "R1");
      rd_check(2'd1, 8'h3F, "R1");
      rd_check(2'd2, 8'h00, "R1");
      live = 1'b1;
      cur_req = "R1";
      wait_periods(1);

      // R2: spare address ignores writes and reads 0
      cur_req = "R2";
      wreg(2'd3, 8'hA5);
      rd_check(2'd3, 8'h00, "R2");
      rd_check(2'd0, 8'hFF, "R2");
      wreg(2'd2, 8'h9B);
      rd_check(2'd2, 8'h9B, "R2");
      wreg(2'd2, 8'h00);

      // R3: duty is level out of 255
      cur_req = "R3";
      wreg(2'd0, 8'h40);
      wait_periods(2);
      window(0, 64, "R3");
      wreg(2'd0, 8'h00);
      wait_periods(2);
      window(3, 0, "R3");
      wreg(2'd0, 8'hFF);
      wait_periods(2);
      window(5, 255, "R3");

      // R4: fixed step, including wrap past the period
      cur_req = "R4";
      wreg(2'd0, 8'd100); wreg(2'd2, 8'd37);
      wait_periods(3);
      wreg(2'd1, 8'h2D); wreg(2'd2, 8'd127);
      wait_periods(3);

      // R5: even spread over enabled channels
      cur_req = "R5";
      wreg(2'd1, 8'h3F); wreg(2'd2, 8'h80);
      wait_periods(3);
      wreg(2'd1, 8'h15);
      wait_periods(3);
      wreg(2'd1, 8'h01);
      wait_periods(2);

      // R6: disabled channels and empty mask
      cur_req = "R6";
      wreg(2'd1, 8'h00);
      wait_periods(2);
      window(2, 0, "R6");
      wreg(2'd1, 8'h0A); wreg(2'd2, 8'd20);
      wait_periods(2);
      window(0, 0, "R6");

      // R7: mid-period writes held to the wrap
      cur_req = "R7";
      wreg(2'd1, 8'h3F);
      repeat (10) @(negedge clk);
      wreg(2'd0, 8'd5);
      repeat (50) @(negedge clk);
      wreg(2'd0, 8'd200);
      wait_periods(2);

      // R8 and R10: faults and status readback
      cur_req = "R8";
      fault = 6'b000101;
      rd_check(2'd1, 8'h3A, "R10");
      wait_periods(1);
      wreg(2'd1, 8'h0F);
      rd_check(2'd1, 8'h0A, "R10");
      fault = 6'b100000;
      rd_check(2'd1, 8'h0F, "R10");
      wait_periods(2);
      fault = '0;
      wait_periods(1);

      // R9: direct mode with several steps
      cur_req = "R9";
      ext_rand = 1'b1;
      wreg(2'd1, 8'h3F);
      dsel = 1'b1;
      wreg(2'd2, 8'd0);
      wait_periods(2);
      wreg(2'd2, 8'd3);
      wait_periods(2);
      wreg(2'd1, 8'h35); wreg(2'd2, 8'd127);
      wait_periods(5);
      fault = 6'b010000;
      wait_periods(1);
      fault = '0;
      dsel = 1'b0;

      // Random rounds
      cur_req = "R4";
      for (int i = 0; i < 16; i++) begin
         repeat ($urandom_range(0, 300)) @(negedge clk);
         case ($urandom_range(0, 4))
            0: wreg(2'd0, 8'($urandom_range(0, 255)));
            1: wreg(2'd1, 8'($urandom_range(0, 63)));
            2: wreg(2'd2, 8'($urandom_range(0, 255)));
            3: dsel = 1'($urandom_range(0, 1));
            default: fault = ($urandom_range(0, 2) == 0) ? 6'($urandom_range(0, 63)) : '0;
         endcase
      end
      wait_periods(2);

      live = 1'b0;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule